// File: doc/BRIEF.md
# Look-Ahead Sequential Read Streamer

The block reads a contiguous run of access words out of a pipelined memory whose read latency is long and varies from one request to the next. Once given a start word address and a word count, it keeps sending read commands in ascending address order. It does not wait for earlier data to come back before sending the next command. The memory returns words strictly in the order the commands were sent. The block holds those words in a small return FIFO and presents them to a downstream consumer through a valid/ready handshake.

The number of words in flight is capped by a credit counter. A word counts against the cap from the cycle its command is accepted until the cycle it leaves the FIFO toward the consumer. This bounds the in-flight words to the FIFO depth, so a stalled consumer never causes returned data to be lost.

A request whose address lies at or beyond the configured region size is never sent. When the next address falls outside the region, the block drops all the requests it has not yet sent and raises a sticky range error. The transfer then ends once the words already in flight have been delivered.

Top module: `seq_read_streamer`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `range_err_o`, `mem_req_valid_o` and `out_valid_o` are all 0.
- R2: Read commands go out back to back without waiting for returned data, so more than one word can be in flight at a time.
- R3: Words in flight (commands accepted minus words handed downstream) never exceed `DEPTH`. With a stalled consumer the count reaches `DEPTH` and no returned word is lost.
- R4: The word addresses of accepted commands are base, base+1, base+2, … in ascending order. The address is held stable while `mem_req_valid_o` is high and `mem_req_ready_i` is low.
- R5: The k-th word delivered downstream is the full `DW`-bit word the memory returned for address base+k, whatever the return latency.
- R6: A start pulse while `busy_o` is high is ignored; the running transfer continues with its own base and count.
- R7: `done_o` is high for exactly one cycle, sampled two clock edges after the edge that takes the last word downstream. `busy_o` falls on the same edge that raises `done_o`.
- R8: A count of zero sends no command and raises `done_o` two edges after the edge that samples the start pulse.
- R9: No command is sent for an address ≥ `REGION_WORDS`. Reaching such an address sets `range_err_o`, drops the requests not yet sent, and still ends the transfer with `done_o` after all in-flight words have been delivered.
- R10: `range_err_o` stays set through later transfers and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, taken only while idle |
| base_addr_i | input | AW | First word address |
| word_cnt_i | input | CW | Number of words to read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| range_err_o | output | 1 | Sticky out-of-region flag |
| mem_req_valid_o | output | 1 | Read command valid |
| mem_req_ready_i | input | 1 | Memory accepts command |
| mem_req_addr_o | output | AW | Read command word address |
| mem_rsp_valid_i | input | 1 | Returned-word strobe |
| mem_rsp_data_i | input | DW | Returned access word |
| out_valid_o | output | 1 | Downstream word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DW | Downstream word |

## Verification
A command that the memory accepts on an edge moves the address forward on that same edge. A word returned on an edge becomes visible as `out_valid_o` right after that edge. `done_o` shows up two edges after the last downstream handshake. For a zero count it shows up two edges after the start is sampled. The bench drives and samples on the falling edge and stamps each handshake, each start and each done with a cycle counter, then checks the exact two-edge distances. The memory model applies a different latency to every command, and the per-word data checks stay independent of that timing because they key on delivery order alone.

// File: rtl/srs_pkg.sv
package srs_pkg;
   // Access widths the streamer accepts for one memory word.
   function automatic bit srs_width_ok(input int w);
      return (w == 64) || (w == 128) || (w == 512);
   endfunction

   function automatic bit srs_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/srs_issue.sv
module srs_issue #(
   parameter int AW           = 16,
   parameter int CW           = 16,
   parameter int REGION_WORDS = 1024
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic [AW-1:0] base_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          credit_ok_i,
   input  logic          drained_i,
   input  logic          req_ready_i,
   output logic          req_valid_o,
   output logic [AW-1:0] req_addr_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o
);
   localparam logic [AW:0] LIMIT = (AW+1)'(REGION_WORDS);

   logic          active_q, done_q, err_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] left_q;
   logic          in_region, fire;

   assign in_region   = {1'b0, addr_q} < LIMIT;
   assign req_valid_o = active_q && (left_q != '0) && in_region && credit_ok_i;
   assign fire        = req_valid_o && req_ready_i;
   assign req_addr_o  = addr_q;
   assign busy_o      = active_q;
   assign done_o      = done_q;
   assign err_o       = err_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         addr_q   <= '0;
         left_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!active_q) begin
            if (start_i) begin
               active_q <= 1'b1;
               addr_q   <= base_i;
               left_q   <= cnt_i;
            end
         end else if (left_q != '0) begin
            if (!in_region) begin
               left_q <= '0;
               err_q  <= 1'b1;
            end else if (fire) begin
               addr_q <= addr_q + 1'b1;
               left_q <= left_q - 1'b1;
            end
         end else if (drained_i) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
         end
      end
   end

   p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

   p_ascend_r4: assert property (@(posedge clk) disable iff (rst)
      (req_valid_o && req_ready_i) |=>
         (!req_valid_o || req_addr_o == AW'($past(req_addr_o) + 1'b1)));

   p_in_region_r9: assert property (@(posedge clk) disable iff (rst)
      req_valid_o |-> ({1'b0, req_addr_o} < LIMIT));

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      err_o |=> err_o);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o);
endmodule

// File: rtl/srs_credit.sv
module srs_credit #(
   parameter int DEPTH = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic take_i,
   input  logic give_i,
   output logic ok_o,
   output logic drained_o
);
   localparam int CRW = $clog2(DEPTH + 1);
   localparam logic [CRW-1:0] CAP = CRW'(DEPTH);

   logic [CRW-1:0] cred_q;

   always_ff @(posedge clk) begin
      if (rst) cred_q <= '0;
      else     cred_q <= cred_q + CRW'(take_i) - CRW'(give_i);
   end

   assign ok_o      = cred_q < CAP;
   assign drained_o = cred_q == '0;

   p_credit_cap_r3: assert property (@(posedge clk) disable iff (rst)
      cred_q <= CAP);

   p_credit_floor_r3: assert property (@(posedge clk) disable iff (rst)
      give_i |-> !drained_o);
endmodule

// File: rtl/srs_fifo.sv
module srs_fifo #(
   parameter int DW    = 128,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          rd_i,
   output logic          valid_o,
   output logic [DW-1:0] rdata_o
);
   localparam int PW = $clog2(DEPTH);

   logic [DW-1:0] slot_q [DEPTH];
   logic [PW:0]   wp_q, rp_q;
   logic          full, empty;

   assign empty   = wp_q == rp_q;
   assign full    = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
   assign valid_o = !empty;
   assign rdata_o = slot_q[rp_q[PW-1:0]];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_i && (wp_q[PW-1:0] == PW'(i))) slot_q[i] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr_i)           wp_q <= wp_q + 1'b1;
         if (rd_i && !empty) rp_q <= rp_q + 1'b1;
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      wr_i |-> !full);
endmodule

// File: rtl/seq_read_streamer.sv
module seq_read_streamer #(
   parameter int AW           = 16,
   parameter int CW           = 16,
   parameter int DW           = 128,
   parameter int DEPTH        = 16,
   parameter int REGION_WORDS = 1024
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic [AW-1:0] base_addr_i,
   input  logic [CW-1:0] word_cnt_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          range_err_o,
   output logic          mem_req_valid_o,
   input  logic          mem_req_ready_i,
   output logic [AW-1:0] mem_req_addr_o,
   input  logic          mem_rsp_valid_i,
   input  logic [DW-1:0] mem_rsp_data_i,
   output logic          out_valid_o,
   input  logic          out_ready_i,
   output logic [DW-1:0] out_data_o
);
   import srs_pkg::*;

   if (!srs_width_ok(DW)) begin : g_bad_width
      $error("seq_read_streamer: DW must be 64, 128 or 512");
   end
   if (!srs_pow2(DEPTH)) begin : g_bad_depth
      $error("seq_read_streamer: DEPTH must be a power of two >= 2");
   end
   if (longint'(REGION_WORDS) > (longint'(1) << AW)) begin : g_bad_region
      $error("seq_read_streamer: REGION_WORDS exceeds address space");
   end

   logic credit_ok, drained, out_fire, req_fire;

   assign req_fire = mem_req_valid_o && mem_req_ready_i;
   assign out_fire = out_valid_o && out_ready_i;

   srs_issue #(.AW(AW), .CW(CW), .REGION_WORDS(REGION_WORDS)) u_issue (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .base_i     (base_addr_i),
      .cnt_i      (word_cnt_i),
      .credit_ok_i(credit_ok),
      .drained_i  (drained),
      .req_ready_i(mem_req_ready_i),
      .req_valid_o(mem_req_valid_o),
      .req_addr_o (mem_req_addr_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .err_o      (range_err_o)
   );

   srs_credit #(.DEPTH(DEPTH)) u_credit (
      .clk      (clk),
      .rst      (rst),
      .take_i   (req_fire),
      .give_i   (out_fire),
      .ok_o     (credit_ok),
      .drained_o(drained)
   );

   srs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .wr_i   (mem_rsp_valid_i),
      .wdata_i(mem_rsp_data_i),
      .rd_i   (out_ready_i),
      .valid_o(out_valid_o),
      .rdata_o(out_data_o)
   );

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> !mem_req_valid_o);
endmodule

// File: tb/tb_seq_read_streamer.sv
module tb_seq_read_streamer;
   localparam int AW = 16, CW = 8, DW = 64, DEPTH = 4, REGION = 40;

   logic          clk = 1'b0, rst = 1'b1;
   logic          start_i = 1'b0;
   logic [AW-1:0] base_addr_i = '0;
   logic [CW-1:0] word_cnt_i = '0;
   logic          busy_o, done_o, range_err_o, mem_req_valid_o, out_valid_o;
   logic          mem_req_ready_i = 1'b0, mem_rsp_valid_i = 1'b0, out_ready_i = 1'b0;
   logic [AW-1:0] mem_req_addr_o;
   logic [DW-1:0] mem_rsp_data_i = '0, out_data_o;

   seq_read_streamer #(.AW(AW), .CW(CW), .DW(DW), .DEPTH(DEPTH), .REGION_WORDS(REGION)) dut (
      .clk(clk), .rst(rst), .start_i(start_i), .base_addr_i(base_addr_i),
      .word_cnt_i(word_cnt_i), .busy_o(busy_o), .done_o(done_o),
      .range_err_o(range_err_o), .mem_req_valid_o(mem_req_valid_o),
      .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
      .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
      .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o));

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0, n_errors = 0;
   int cur_base = 0, nreq = 0, ndel = 0, max_out = 0;
   int hs_cyc = 0, done_cyc = 0, start_cyc = 0;
   int req_mode = 0, out_mode = 0, stall_left = 0;
   bit done_seen = 0, order_bad = 0, data_bad = 0;

   function automatic logic [DW-1:0] mem_word(input int a);
      logic [31:0] w;
      w = 32'(a) * 32'h9E37 + 32'h1357;
      return {(DW/32){w}};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Memory model: in-order queue with a latency that varies per command.
   int q_addr[$];
   int q_due[$];
   initial begin
      int lat_seed = 5, last_due = 0;
      forever begin
         @(negedge clk);
         if (rst) begin
            q_addr.delete(); q_due.delete();
            mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0;
         end else begin
            mem_req_ready_i = (req_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (mem_req_valid_o && mem_req_ready_i) begin
               int a, due;
               a = int'(mem_req_addr_o);
               if (a != cur_base + nreq) order_bad = 1;
               nreq++;
               if (nreq - ndel > max_out) max_out = nreq - ndel;
               lat_seed = (lat_seed * 7 + 3) % 13;
               due = cyc + 2 + lat_seed;
               if (due <= last_due) due = last_due + 1;
               last_due = due;
               q_addr.push_back(a); q_due.push_back(due);
            end
            if (q_due.size() > 0 && q_due[0] <= cyc) begin
               mem_rsp_valid_i = 1'b1;
               mem_rsp_data_i  = mem_word(q_addr[0]);
               void'(q_addr.pop_front()); void'(q_due.pop_front());
            end else begin
               mem_rsp_valid_i = 1'b0;
            end
         end
      end
   end

   // Downstream driver and monitor.
   initial begin
      forever begin
         @(negedge clk);
         if (rst) out_ready_i = 1'b0;
         else begin
            case (out_mode)
               0: out_ready_i = 1'b1;
               1: out_ready_i = cyc[0];
               default: begin
                  if (stall_left > 0) begin stall_left--; out_ready_i = 1'b0; end
                  else out_ready_i = 1'b1;
               end
            endcase
            if (out_valid_o && out_ready_i) begin
               if (out_data_o !== mem_word(cur_base + ndel)) data_bad = 1;
               ndel++;
               hs_cyc = cyc;
            end
            if (done_o) begin done_seen = 1; done_cyc = cyc; end
         end
      end
   end

   task automatic run(input int base, input int cnt, input int rm, input int om,
                      input int stall, input int exp_words, input string tag);
      int t;
      @(negedge clk);
      cur_base = base; nreq = 0; ndel = 0; max_out = 0;
      done_seen = 0; order_bad = 0; data_bad = 0;
      req_mode = rm; out_mode = om; stall_left = stall;
      base_addr_i = AW'(base); word_cnt_i = CW'(cnt); start_i = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      start_i = 1'b0;
      t = 0;
      while (!done_seen && t < 2000) begin @(negedge clk); t++; end
      check(done_seen, {tag, " R7 done reached"}, done_seen, 1);
      check(ndel == exp_words, {tag, " R5 word count"}, ndel, exp_words);
      check(nreq == exp_words, {tag, " R4 command count"}, nreq, exp_words);
      check(!order_bad, {tag, " R4 ascending addresses"}, order_bad, 0);
      check(!data_bad, {tag, " R5 data in order"}, data_bad, 0);
      check(max_out <= DEPTH, {tag, " R3 in-flight cap"}, max_out, DEPTH);
      if (exp_words > 0)
         check(done_cyc - hs_cyc == 2, {tag, " R7 done timing"}, done_cyc - hs_cyc, 2);
      @(negedge clk);
      check(!done_o && !busy_o, {tag, " R7 done single pulse"}, done_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check(!busy_o, "R1 busy", busy_o, 0);
      check(!done_o, "R1 done", done_o, 0);
      check(!range_err_o, "R1 err", range_err_o, 0);
      check(!mem_req_valid_o, "R1 req_valid", mem_req_valid_o, 0);
      check(!out_valid_o, "R1 out_valid", out_valid_o, 0);

      // R2 look-ahead under free flow
      run(0, 12, 0, 0, 0, 12, "free");
      check(max_out > 1, "R2 look-ahead depth", max_out, 2);

      // R3 stalled consumer fills the FIFO without loss
      run(10, 16, 0, 2, 40, 16, "stall");
      check(max_out == DEPTH, "R3 reaches cap", max_out, DEPTH);

      // Near-exhaustive sweep over bases, counts and handshake patterns
      for (int b = 0; b < 3; b++)
         for (int c = 1; c <= 9; c++)
            run(b * 11, c, c % 2, (b + c) % 3, 7, c, "sweep");

      // R6 start while busy is ignored
      @(negedge clk);
      cur_base = 0; nreq = 0; ndel = 0; max_out = 0;
      done_seen = 0; order_bad = 0; data_bad = 0;
      req_mode = 0; out_mode = 1;
      base_addr_i = AW'(0); word_cnt_i = CW'(10); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (4) @(negedge clk);
      base_addr_i = AW'(30); word_cnt_i = CW'(3); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      for (int t = 0; t < 2000 && !done_seen; t++) @(negedge clk);
      check(ndel == 10, "R6 words of first transfer", ndel, 10);
      check(!data_bad && !order_bad, "R6 first base kept", data_bad, 0);
      @(negedge clk);

      // R8 zero count
      run(5, 0, 0, 0, 0, 0, "zero");
      check(done_cyc - start_cyc == 2, "R8 zero-count done timing", done_cyc - start_cyc, 2);
      check(!range_err_o, "R8 no error", range_err_o, 0);

      // R9 region overrun: words 35..39 only
      run(35, 10, 1, 1, 0, 5, "range");
      check(range_err_o, "R9 error raised", range_err_o, 1);
      run(REGION, 2, 0, 0, 0, 0, "range0");

      // R10 sticky across a clean transfer, cleared by reset
      run(0, 3, 0, 0, 0, 3, "after");
      check(range_err_o, "R10 error sticky", range_err_o, 1);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      check(!range_err_o, "R10 cleared by reset", range_err_o, 0);
      check(!busy_o && !out_valid_o, "R1 idle after reset", busy_o, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule